// File: doc/BRIEF.md
# Ethernet Pause Frame Transmit Scheduler

This block sits beside a full-duplex Ethernet MAC transmitter. It decides when a flow-control PAUSE frame has to go out and which pause-quanta value that frame carries. The receive buffer raises a level request when it is close to overflowing. The scheduler answers by asking the frame transmitter for a PAUSE frame that carries the configured pause time. It then runs a countdown of slot times so that it can renew the pause before the link partner's own timer runs out. When the buffer drops its request, the scheduler asks for a zero-quanta frame so that the partner resumes at once.

Time is measured in slot times. One slot time is 512 bit times, which is 128 nibble transfers on a 4-bit MII-style datapath. A nibble-clock enable input drives the internal slot counter. A 2-bit threshold select picks how far below the configured pause time the countdown must fall before the request level is checked again. The frame transmitter sees a simple request/acknowledge pair, and the quanta value is held stable while the request is pending.

Top module: `pause_tx_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `frm_req` is 0 and `frm_quanta` is 0.
- R2: If `cfg_tx_fc_en` is 1, `fc_req` is 1, the countdown is idle (zero) and no non-zero frame has been acknowledged in the current request episode, `frm_req` rises at the next clock edge with `frm_quanta` equal to `cfg_pause_time`.
- R3: Once raised, `frm_req` and `frm_quanta` hold their values until a clock edge that sees `frm_ack` high. `frm_req` is low after that edge, and only one request is outstanding at a time.
- R4: Acknowledging a non-zero frame loads the countdown with `cfg_pause_time` and restarts the slot counter. The countdown then drops by one every 128 asserted `nib_en` cycles.
- R5: The threshold is `cfg_pause_time` minus an offset picked by `cfg_thresh_sel`: 4 for 00, 28 for 01, 144 for 10, 256 for 11. When the countdown falls to the threshold while `fc_req` is 1, a new request carrying `cfg_pause_time` appears. With `nib_en` held at 1, this happens 128*(pause time - threshold)+2 clock edges after the acknowledging edge. If `fc_req` is 0 at that moment, no request is made.
- R6: If the offset is greater than or equal to the pause time, the threshold is 0, and the re-check takes place when the countdown expires.
- R7: A zero-quanta request (`frm_quanta` = 0) is made at the first edge where `fc_req` is 0 after a non-zero frame was acknowledged in the episode. No zero-quanta request is made if no non-zero frame was acknowledged. Acknowledging the zero-quanta frame clears the countdown to idle.
- R8: With `cfg_zq_dis` at 1, releasing `fc_req` produces no zero-quanta request.
- R9: While `cfg_tx_fc_en` is 0, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_en | input | 1 | One nibble transferred on the datapath this cycle |
| fc_req | input | 1 | Level flow-control request from the receive buffer |
| cfg_pause_time | input | 16 | Pause time in slot times |
| cfg_thresh_sel | input | 2 | Re-check threshold select |
| cfg_zq_dis | input | 1 | Suppress automatic zero-quanta frames |
| cfg_tx_fc_en | input | 1 | Allow PAUSE frame generation |
| frm_req | output | 1 | Request to the frame transmitter |
| frm_ack | input | 1 | Transmitter accepts the pending request |
| frm_quanta | output | 16 | Pause-quanta value of the pending request |

## Verification
Each of the four threshold selects is run with `nib_en` held high, and the exact gap from acknowledge to re-send is measured, so that an offset error or an off-by-one in the slot count shows as a different cycle count. A pause time below the offset separates the clamped threshold from a wrapped one. Directed runs with the enable low, with zero-quanta disabled and with the request released before the threshold show that each gate suppresses its own frame. A long random run toggles the request, thins the nibble enables and delays acknowledges at random, and checks on every new request that its quanta fits the request level and the episode history.

// File: rtl/pause_sched_pkg.sv
package pause_sched_pkg;

  // Offset below the pause time at which the request level is re-checked (R5)
  function automatic logic [15:0] thresh_offset(input logic [1:0] sel);
    logic [15:0] off;
    case (sel)
      2'b00:   off = 16'd4;
      2'b01:   off = 16'd28;
      2'b10:   off = 16'd144;
      default: off = 16'd256;
    endcase
    return off;
  endfunction

endpackage

// File: rtl/slot_tick_gen.sv
module slot_tick_gen #(
  parameter int NIBS_PER_SLOT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic nib_en,
  output logic tick
);
  localparam int CW = (NIBS_PER_SLOT > 1) ? $clog2(NIBS_PER_SLOT) : 1;
  localparam logic [CW-1:0] LAST = CW'(NIBS_PER_SLOT - 1);

  logic [CW-1:0] cnt;

  // R4: one registered tick per NIBS_PER_SLOT nibble enables
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (run && nib_en) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pause_countdown.sv
module pause_countdown #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [QW-1:0] load_val,
  input  logic          tick,
  input  logic [QW-1:0] thresh,
  output logic          idle,
  output logic          hit
);
  logic [QW-1:0] remain;
  logic [QW-1:0] next_remain;

  assign next_remain = remain - 1'b1;
  assign idle        = (remain == '0);

  // R4/R5: count down per slot; flag the step that lands on the threshold
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      hit    <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (load_en) begin
        remain <= load_val;
      end else if (tick && !idle) begin
        remain <= next_remain;
        hit    <= (next_remain == thresh);
      end
    end
  end
endmodule

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fc_req,
  input  logic          tx_en,
  input  logic          zq_dis,
  input  logic [QW-1:0] pause_time,
  input  logic          timer_idle,
  input  logic          timer_hit,
  input  logic          ack,
  output logic          req,
  output logic [QW-1:0] quanta,
  output logic          req_zero,
  output logic          take
);
  logic sent_nz;

  assign take = req & ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      req_zero <= 1'b0;
      quanta   <= '0;
      sent_nz  <= 1'b0;
    end else if (req) begin
      // R3: hold until acknowledged
      if (ack) begin
        req     <= 1'b0;
        sent_nz <= !req_zero;
      end
    end else if (tx_en && fc_req && timer_idle && !sent_nz) begin
      // R2: first request of an episode
      req      <= 1'b1;
      req_zero <= 1'b0;
      quanta   <= pause_time;
    end else if (tx_en && fc_req && timer_hit) begin
      // R5: renewal at threshold
      req      <= 1'b1;
      req_zero <= 1'b0;
      quanta   <= pause_time;
    end else if (tx_en && !fc_req && sent_nz && !zq_dis) begin
      // R7: zero-quanta on release
      req      <= 1'b1;
      req_zero <= 1'b1;
      quanta   <= '0;
    end else if (!fc_req && (zq_dis || !tx_en)) begin
      // R8/R9: episode ends without a zero-quanta frame
      sent_nz <= 1'b0;
    end
  end
endmodule

// File: rtl/pause_tx_sched.sv
module pause_tx_sched #(
  parameter int QW            = 16,
  parameter int NIBS_PER_SLOT = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nib_en,
  input  logic          fc_req,
  input  logic [QW-1:0] cfg_pause_time,
  input  logic [1:0]    cfg_thresh_sel,
  input  logic          cfg_zq_dis,
  input  logic          cfg_tx_fc_en,
  output logic          frm_req,
  input  logic          frm_ack,
  output logic [QW-1:0] frm_quanta
);
  import pause_sched_pkg::*;

  logic [QW-1:0] offset;
  logic [QW-1:0] thresh;
  logic          req_zero;
  logic          take;
  logic          load_en;
  logic [QW-1:0] load_val;
  logic          slot_tick;
  logic          timer_idle;
  logic          timer_hit;

  // R5/R6: threshold clamps at zero instead of wrapping
  assign offset   = QW'(thresh_offset(cfg_thresh_sel));
  assign thresh   = (cfg_pause_time > offset) ? (cfg_pause_time - offset) : '0;

  // R4/R7: load on non-zero acknowledge, clear on zero-quanta acknowledge
  assign load_en  = take;
  assign load_val = req_zero ? '0 : cfg_pause_time;

  slot_tick_gen #(.NIBS_PER_SLOT(NIBS_PER_SLOT)) u_slot (
    .clk    (clk),
    .rst    (rst),
    .clr    (load_en),
    .run    (!timer_idle),
    .nib_en (nib_en),
    .tick   (slot_tick)
  );

  pause_countdown #(.QW(QW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (load_val),
    .tick     (slot_tick),
    .thresh   (thresh),
    .idle     (timer_idle),
    .hit      (timer_hit)
  );

  pause_req_ctrl #(.QW(QW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fc_req     (fc_req),
    .tx_en      (cfg_tx_fc_en),
    .zq_dis     (cfg_zq_dis),
    .pause_time (cfg_pause_time),
    .timer_idle (timer_idle),
    .timer_hit  (timer_hit),
    .ack        (frm_ack),
    .req        (frm_req),
    .quanta     (frm_quanta),
    .req_zero   (req_zero),
    .take       (take)
  );
endmodule

// File: rtl/pause_tx_sched_chk.sv
module pause_tx_sched_chk #(
  parameter int QW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_zq_dis,
  input logic          cfg_tx_fc_en,
  input logic          frm_req,
  input logic          frm_ack,
  input logic [QW-1:0] frm_quanta,
  input logic          req_zero
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!frm_req && frm_quanta == '0));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_req && !frm_ack) |=> (frm_req && $stable(frm_quanta)));

  // R3
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_req && frm_ack) |=> !frm_req);

  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frm_req) |-> $past(cfg_tx_fc_en));

  // R8
  zq_disable_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(frm_req) && req_zero) |-> !$past(cfg_zq_dis));

  // R7
  zero_quanta_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_req && req_zero) |-> (frm_quanta == '0));
endmodule

bind pause_tx_sched pause_tx_sched_chk #(.QW(QW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_zq_dis   (cfg_zq_dis),
  .cfg_tx_fc_en (cfg_tx_fc_en),
  .frm_req      (frm_req),
  .frm_ack      (frm_ack),
  .frm_quanta   (frm_quanta),
  .req_zero     (req_zero)
);

// File: tb/test_pause_tx_sched.sv
`timescale 1ns/1ps
module test_pause_tx_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nib_en = 1'b1;
  logic        fc_req = 1'b0;
  logic [15:0] cfg_pause_time = '0;
  logic [1:0]  cfg_thresh_sel = '0;
  logic        cfg_zq_dis = 1'b0;
  logic        cfg_tx_fc_en = 1'b0;
  logic        frm_req;
  logic        frm_ack = 1'b0;
  logic [15:0] frm_quanta;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pause_tx_sched i_pause_tx_sched (
    .clk(clk), .rst(rst), .nib_en(nib_en), .fc_req(fc_req),
    .cfg_pause_time(cfg_pause_time), .cfg_thresh_sel(cfg_thresh_sel),
    .cfg_zq_dis(cfg_zq_dis), .cfg_tx_fc_en(cfg_tx_fc_en),
    .frm_req(frm_req), .frm_ack(frm_ack), .frm_quanta(frm_quanta)
  );

  function automatic int exp_thresh(input int pt, input int sel);
    int off;
    case (sel)
      0: off = 4;
      1: off = 28;
      2: off = 144;
      default: off = 256;
    endcase
    return (pt > off) ? pt - off : 0;
  endfunction

  function automatic int exp_gap(input int pt, input int sel);
    return 128 * (pt - exp_thresh(pt, sel)) + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    fc_req = 1'b0;
    frm_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(!frm_req && frm_quanta == 0, "R1 during reset", int'(frm_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!frm_req && frm_quanta == 0, "R1 after reset", int'(frm_quanta), 0);
  endtask

  task automatic ack_frame();
    frm_ack = 1'b1;
    @(negedge clk);
    frm_ack = 1'b0;
  endtask

  task automatic wait_req(output int n, input int limit);
    n = 0;
    while (!frm_req && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_thresh(input int pt, input int sel, input string tag);
    int n;
    cfg_pause_time = 16'(pt);
    cfg_thresh_sel = 2'(sel);
    fc_req = 1'b1;
    @(negedge clk);
    chk(frm_req && frm_quanta == 16'(pt), "R2 first request", int'(frm_quanta), pt);
    repeat (3) @(negedge clk);
    chk(frm_req && frm_quanta == 16'(pt), "R3 held without ack", int'(frm_quanta), pt);
    ack_frame();
    chk(!frm_req, "R3 drop after ack", int'(frm_req), 0);
    wait_req(n, 40000);
    chk(n == exp_gap(pt, sel), tag, n, exp_gap(pt, sel));
    chk(frm_quanta == 16'(pt), "R5 renewal quanta", int'(frm_quanta), pt);
    ack_frame();
    fc_req = 1'b0;
    @(negedge clk);
    chk(frm_req && frm_quanta == 0, "R7 zero-quanta on release", int'(frm_req), 1);
    ack_frame();
  endtask

  initial begin
    int n;
    bit seen;
    cfg_tx_fc_en = 1'b1;
    do_reset();

    // R7: no zero-quanta without an earlier non-zero frame
    seen = 0;
    repeat (50) begin @(negedge clk); seen |= frm_req; end
    chk(!seen, "R7 no frame while idle", int'(seen), 0);

    // R4/R5 on each threshold select, R6 on underflow
    run_thresh(10, 0, "R4 R5 gap sel 00");
    run_thresh(40, 1, "R5 gap sel 01");
    run_thresh(200, 2, "R5 gap sel 10");
    run_thresh(300, 3, "R5 gap sel 11");
    run_thresh(5, 3, "R6 underflow gap");
    run_thresh(20, 1, "R6 underflow gap sel 01");

    // R9: disabled transmit flow control
    do_reset();
    cfg_tx_fc_en = 1'b0;
    cfg_pause_time = 16'd12;
    cfg_thresh_sel = 2'd0;
    fc_req = 1'b1;
    seen = 0;
    repeat (50) begin @(negedge clk); seen |= frm_req; end
    chk(!seen, "R9 no request while disabled", int'(seen), 0);
    cfg_tx_fc_en = 1'b1;
    @(negedge clk);
    chk(frm_req && frm_quanta == 16'd12, "R9 request once enabled", int'(frm_req), 1);
    ack_frame();

    // R8 and R5: release before threshold with zero-quanta disabled
    cfg_zq_dis = 1'b1;
    fc_req = 1'b0;
    seen = 0;
    repeat (128 * 12 + 50) begin @(negedge clk); seen |= frm_req; end
    chk(!seen, "R8 R5 no frame after release", int'(seen), 0);
    cfg_zq_dis = 1'b0;

    // Random phase
    begin
      int pt;
      bit last_fc, prev_req, prev_ack, nz_acked;
      logic [15:0] prev_q;
      void'($urandom(32'd4242));
      do_reset();
      pt = 1 + int'($urandom % 30);
      cfg_pause_time = 16'(pt);
      cfg_thresh_sel = 2'($urandom % 4);
      last_fc = 0; prev_req = 0; prev_ack = 0; nz_acked = 0; prev_q = '0;
      for (int c = 0; c < 60000; c++) begin
        @(negedge clk);
        if (frm_req && !prev_req) begin
          if (!last_fc) begin
            chk(frm_quanta == 0, "R7 random zero quanta", int'(frm_quanta), 0);
            chk(nz_acked, "R7 random zero after non-zero", int'(nz_acked), 1);
          end else begin
            chk(frm_quanta == 16'(pt), "R2 R5 random quanta", int'(frm_quanta), pt);
          end
        end
        if (prev_req && !prev_ack)
          chk(frm_req && frm_quanta == prev_q, "R3 random hold", int'(frm_quanta), int'(prev_q));
        if (prev_req && prev_ack)
          chk(!frm_req, "R3 random drop", int'(frm_req), 0);
        prev_req = frm_req;
        prev_q = frm_quanta;
        frm_ack = frm_req && ($urandom % 4 == 0);
        prev_ack = frm_ack;
        if (frm_ack) nz_acked = (frm_quanta != 0);
        if ($urandom % 2000 == 0) fc_req = !fc_req;
        nib_en = ($urandom % 8 != 0);
        last_fc = fc_req;
      end
      frm_ack = 1'b0;
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule